// File: doc/BRIEF.md
# Wishbone to CSR Register Bus Bridge

This block sits between a Wishbone classic slave port and a narrow control/status register bus. The register bus carries 8, 16, 32 or 64 data bits. The Wishbone side may be the same width or a whole multiple of it. Each CSR-sized slice of the Wishbone word is a lane, and each lane has one select bit.

A single Wishbone access is broken into one register-bus sub-cycle per lane, visited from the lowest lane to the highest. Lanes whose select bit is clear are skipped without a strobe. Read data coming back from the register bus is collected lane by lane into a holding word, and unselected lanes read as zero. The Wishbone acknowledge is a one-cycle pulse raised only after the last lane has been handled.

If the register-bus width parameter is not 8, 16, 32 or 64, or the Wishbone width is not a whole multiple of it, elaboration stops with an error.

Top module: `wb_csr_bridge`

## Requirements
- R1: After reset, `csr_re`, `csr_we` and `wb_ack` are all low.
- R2: An access is accepted in an idle cycle in which `wb_cyc` and `wb_stb` are both high. Lane k (0 = least significant) is handled in the (k+1)-th cycle after the accepting cycle, one lane per cycle, in ascending order.
- R3: The sub-cycle for lane k uses CSR address `wb_adr*LANES + k`. Its write data is `wb_dat_w[k*CSR_DW +: CSR_DW]`. LANES is WB_DW/CSR_DW.
- R4: A lane strobes only if `wb_sel[k]` is 1. It raises `csr_we` when `wb_we` is 1 and `csr_re` otherwise, and the two strobes are never high together. An unselected lane changes no register.
- R5: `csr_rdat` is taken one clock after a lane's read strobe and placed in that lane of `wb_dat_r`. Unselected lanes read as zero. For example, select 0110 over bytes 44,33,22,11 gives 0x00332200.
- R6: `wb_ack` is a single-cycle pulse in the (LANES+2)-th cycle after the accepting cycle, with `wb_dat_r` valid in that cycle.
- R7: If `wb_cyc` or `wb_stb` drops before the acknowledge, the remaining lanes are abandoned. No further strobe and no acknowledge follow.
- R8: The cycle after the acknowledge is an idle cycle with no strobe. A request still held during it is accepted there, so the next acknowledge comes LANES+3 cycles after the previous one.
- R9: When WB_DW equals CSR_DW, `wb_sel` is one bit wide. Each access then makes exactly one sub-cycle at the same address as `wb_adr`, and the acknowledge follows two cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wb_cyc | input | 1 | Wishbone cycle |
| wb_stb | input | 1 | Wishbone strobe |
| wb_we | input | 1 | Wishbone write enable |
| wb_adr | input | WB_AW | Wishbone word address |
| wb_sel | input | WB_DW/CSR_DW | Per-lane select |
| wb_dat_w | input | WB_DW | Wishbone write data |
| wb_dat_r | output | WB_DW | Gathered read data |
| wb_ack | output | 1 | Acknowledge pulse |
| csr_adr | output | WB_AW+log2(WB_DW/CSR_DW) | Register bus address |
| csr_re | output | 1 | Register read strobe |
| csr_we | output | 1 | Register write strobe |
| csr_wdat | output | CSR_DW | Register write data |
| csr_rdat | input | CSR_DW | Register read data, valid one clock after `csr_re` |

## Verification
The assertions check on every cycle the rules that hold at any instant. The strobes are exclusive, and a strobe appears only under a live request and a set select bit. Each strobe carries the address and write-data slice of its lane. The acknowledge is one cycle long and is followed by a strobe-free cycle. What only the bench's scenarios can show is the lane ordering, the exact acknowledge latency and back-to-back spacing, and the zero-filled assembly of read data. They also show that an abandoned access leaves its later lanes unwritten and that the equal-width configuration makes exactly one sub-cycle.

// File: rtl/wbcsr_pkg.sv
`timescale 1ns/1ps
package wbcsr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LANE = 2'd1,
    ST_FIN  = 2'd2,
    ST_ACK  = 2'd3
  } wbcsr_state_e;
endpackage

// File: rtl/wbcsr_lane_seq.sv
`timescale 1ns/1ps
module wbcsr_lane_seq
  import wbcsr_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output wbcsr_state_e      state_o,
  output logic [LANE_W-1:0] lane_o
);
  localparam logic [LANE_W-1:0] LAST = LANE_W'(LANES - 1);

  wbcsr_state_e      state_q;
  logic [LANE_W-1:0] lane_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lane_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (go) begin
          state_q <= ST_LANE;
          lane_q  <= '0;
        end
        ST_LANE: begin
          if (!go)                state_q <= ST_IDLE;
          else if (lane_q == LAST) state_q <= ST_FIN;
          else                    lane_q  <= lane_q + LANE_W'(1);
        end
        ST_FIN:  state_q <= go ? ST_ACK : ST_IDLE;
        ST_ACK:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign lane_o  = lane_q;
endmodule

// File: rtl/wbcsr_rd_gather.sv
`timescale 1ns/1ps
module wbcsr_rd_gather #(
  parameter int LANES  = 4,
  parameter int CSR_DW = 8,
  parameter int LANE_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    cap_en,
  input  logic [LANE_W-1:0]       cap_lane,
  input  logic [CSR_DW-1:0]       cap_data,
  output logic [LANES*CSR_DW-1:0] hold_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [CSR_DW-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   slot_q <= '0;
      else if (clear)                               slot_q <= '0;
      else if (cap_en && cap_lane == LANE_W'(i))    slot_q <= cap_data;
    end
    assign hold_o[i*CSR_DW +: CSR_DW] = slot_q;
  end
endmodule

// File: rtl/wb_csr_bridge.sv
`timescale 1ns/1ps
module wb_csr_bridge
  import wbcsr_pkg::*;
#(
  parameter int WB_DW  = 32,
  parameter int CSR_DW = 8,
  parameter int WB_AW  = 8
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        wb_cyc,
  input  logic                                        wb_stb,
  input  logic                                        wb_we,
  input  logic [WB_AW-1:0]                            wb_adr,
  input  logic [WB_DW/CSR_DW-1:0]                     wb_sel,
  input  logic [WB_DW-1:0]                            wb_dat_w,
  output logic [WB_DW-1:0]                            wb_dat_r,
  output logic                                        wb_ack,
  output logic [WB_AW+$clog2(WB_DW/CSR_DW)-1:0]       csr_adr,
  output logic                                        csr_re,
  output logic                                        csr_we,
  output logic [CSR_DW-1:0]                           csr_wdat,
  input  logic [CSR_DW-1:0]                           csr_rdat
);
  localparam int LANES  = WB_DW / CSR_DW;
  localparam int ADR_SH = $clog2(LANES);
  localparam int LANE_W = (LANES > 1) ? ADR_SH : 1;
  localparam int CSR_AW = WB_AW + ADR_SH;

  if (!(CSR_DW == 8 || CSR_DW == 16 || CSR_DW == 32 || CSR_DW == 64)) begin : g_bad_csr_dw
    $error("register bus width must be 8, 16, 32 or 64");
  end
  if (WB_DW < CSR_DW || (WB_DW % CSR_DW) != 0) begin : g_bad_ratio
    $error("Wishbone width must be a whole multiple of the register bus width");
  end

  function automatic logic [CSR_AW-1:0] lane_addr(input logic [WB_AW-1:0] a,
                                                  input logic [LANE_W-1:0] k);
    return (CSR_AW'(a) << ADR_SH) | CSR_AW'(k);
  endfunction

  function automatic logic [CSR_DW-1:0] lane_data(input logic [WB_DW-1:0] d,
                                                  input logic [LANE_W-1:0] k);
    return d[k*CSR_DW +: CSR_DW];
  endfunction

  wbcsr_state_e      state;
  logic [LANE_W-1:0] cur_lane;
  logic              go;
  logic              rd_pend_q;
  logic [LANE_W-1:0] rd_lane_q;

  // named events for the checker
  logic evt_start, evt_issue, evt_cap, evt_ack;

  assign go = wb_cyc & wb_stb;

  wbcsr_lane_seq #(.LANES(LANES), .LANE_W(LANE_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .state_o (state),
    .lane_o  (cur_lane)
  );

  assign evt_start = (state == ST_IDLE) && go;
  assign evt_issue = (state == ST_LANE) && go && wb_sel[cur_lane];
  assign evt_ack   = (state == ST_ACK);
  assign evt_cap   = rd_pend_q;

  assign csr_re   = evt_issue && !wb_we;
  assign csr_we   = evt_issue && wb_we;
  assign csr_adr  = lane_addr(wb_adr, cur_lane);
  assign csr_wdat = lane_data(wb_dat_w, cur_lane);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      rd_lane_q <= '0;
    end else begin
      rd_pend_q <= csr_re;
      rd_lane_q <= cur_lane;
    end
  end

  wbcsr_rd_gather #(.LANES(LANES), .CSR_DW(CSR_DW), .LANE_W(LANE_W)) u_gather (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (evt_start),
    .cap_en   (evt_cap),
    .cap_lane (rd_lane_q),
    .cap_data (csr_rdat),
    .hold_o   (wb_dat_r)
  );

  assign wb_ack = evt_ack;
endmodule

// File: rtl/wbcsr_chk.sv
`timescale 1ns/1ps
module wbcsr_chk #(
  parameter int WB_DW  = 32,
  parameter int CSR_DW = 8,
  parameter int WB_AW  = 8
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  wb_cyc,
  input logic                                  wb_stb,
  input logic                                  wb_we,
  input logic [WB_AW-1:0]                      wb_adr,
  input logic [WB_DW/CSR_DW-1:0]               wb_sel,
  input logic [WB_DW-1:0]                      wb_dat_w,
  input logic                                  wb_ack,
  input logic [WB_AW+$clog2(WB_DW/CSR_DW)-1:0] csr_adr,
  input logic                                  csr_re,
  input logic                                  csr_we,
  input logic [CSR_DW-1:0]                     csr_wdat,
  input logic                                  evt_start
);
  localparam int LANES  = WB_DW / CSR_DW;
  localparam int ADR_SH = $clog2(LANES);
  localparam int CSR_AW = WB_AW + ADR_SH;

  function automatic int adr_lane(input logic [CSR_AW-1:0] a);
    return int'(a) % LANES;
  endfunction

  logic strobe;
  assign strobe = csr_re || csr_we;

  a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_re && csr_we));
  a_r4_selected_lane_only: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> wb_sel[adr_lane(csr_adr)] && (csr_we == wb_we));
  a_r3_lane_address: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (csr_adr >> ADR_SH) == CSR_AW'(wb_adr));
  a_r3_lane_wdata: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |-> csr_wdat == CSR_DW'(wb_dat_w >> (CSR_DW * adr_lane(csr_adr))));
  a_r7_live_request: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> wb_cyc && wb_stb);
  a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ack |=> !wb_ack);
  a_r6_no_early_ack: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start |=> !wb_ack);
  a_r8_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ack |=> !strobe);
  a_r8_start_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start |-> !wb_ack && !strobe);
endmodule

bind wb_csr_bridge wbcsr_chk #(.WB_DW(WB_DW), .CSR_DW(CSR_DW), .WB_AW(WB_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wb_cyc    (wb_cyc),
  .wb_stb    (wb_stb),
  .wb_we     (wb_we),
  .wb_adr    (wb_adr),
  .wb_sel    (wb_sel),
  .wb_dat_w  (wb_dat_w),
  .wb_ack    (wb_ack),
  .csr_adr   (csr_adr),
  .csr_re    (csr_re),
  .csr_we    (csr_we),
  .csr_wdat  (csr_wdat),
  .evt_start (evt_start)
);

// File: tb/wb_csr_bridge_tb_top.sv
`timescale 1ns/1ps
module wb_csr_bridge_tb_top;
  localparam int L = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        wb_cyc = 0, wb_stb = 0, wb_we = 0;
  logic [7:0]  wb_adr = '0;
  logic [3:0]  wb_sel = '0;
  logic [31:0] wb_dat_w = '0;
  logic [31:0] wb_dat_r;
  logic        wb_ack;
  logic [9:0]  csr_adr;
  logic        csr_re, csr_we;
  logic [7:0]  csr_wdat;
  logic [7:0]  rdat_q = '0;

  wb_csr_bridge #(.WB_DW(32), .CSR_DW(8), .WB_AW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_sel(wb_sel), .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r),
    .wb_ack(wb_ack), .csr_adr(csr_adr), .csr_re(csr_re), .csr_we(csr_we),
    .csr_wdat(csr_wdat), .csr_rdat(rdat_q));

  // equal-width configuration (R9)
  logic        e_cyc = 0, e_stb = 0, e_we = 0;
  logic [5:0]  e_adr = '0;
  logic [0:0]  e_sel = '0;
  logic [15:0] e_dat_w = '0, e_dat_r, e_wdat;
  logic        e_ack, e_re, e_we_o;
  logic [5:0]  e_csr_adr;
  logic [15:0] e_rdat_q = '0;

  wb_csr_bridge #(.WB_DW(16), .CSR_DW(16), .WB_AW(6)) dut_eq_i (
    .clk(clk), .rst_n(rst_n), .wb_cyc(e_cyc), .wb_stb(e_stb), .wb_we(e_we),
    .wb_adr(e_adr), .wb_sel(e_sel), .wb_dat_w(e_dat_w), .wb_dat_r(e_dat_r),
    .wb_ack(e_ack), .csr_adr(e_csr_adr), .csr_re(e_re), .csr_we(e_we_o),
    .csr_wdat(e_wdat), .csr_rdat(e_rdat_q));

  // register-bus slaves
  logic [7:0] mem [0:1023];
  logic [9:0] wq [$];
  always @(posedge clk) begin
    if (csr_we) begin mem[csr_adr] <= csr_wdat; wq.push_back(csr_adr); end
    if (csr_re) rdat_q <= mem[csr_adr];
    if (e_re) e_rdat_q <= 16'hA500 | 16'(e_csr_adr);
  end

  int n_chk = 0, n_err = 0;
  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural reference: cycles since acceptance, 0 = idle
  int m_cnt = 0;
  bit m_pend = 0;
  int m_pend_lane = 0;
  logic [31:0] m_hold = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pend = 0; m_hold = '0;
    end else begin
      bit g, iss;
      int ln;
      g = wb_cyc && wb_stb;
      ln = m_cnt - 1;
      iss = 0;
      if (m_cnt >= 1 && m_cnt <= L) iss = g && wb_sel[ln];
      if (m_pend) m_hold[m_pend_lane*8 +: 8] = rdat_q;
      m_pend = iss && !wb_we;
      m_pend_lane = ln;
      if (m_cnt == 0) begin
        if (g) begin m_cnt = 1; m_hold = '0; end
      end else if (m_cnt <= L + 1) begin
        m_cnt = g ? m_cnt + 1 : 0;
      end else begin
        m_cnt = 0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        bit g, inl, iss;
        int ln;
        string tag;
        g = wb_cyc && wb_stb;
        inl = (m_cnt >= 1 && m_cnt <= L);
        ln = inl ? m_cnt - 1 : 0;
        iss = g && inl && wb_sel[ln];
        tag = !inl ? "R8" : !g ? "R7" : !wb_sel[ln] ? "R4" : "R2";
        chk(tag, "strobes {re,we}", {62'd0, csr_re, csr_we}, {62'd0, iss && !wb_we, iss && wb_we});
        if (iss) begin
          chk("R3", "csr_adr", 64'(csr_adr), 64'(wb_adr * L + ln));
          if (wb_we) chk("R3", "csr_wdat", 64'(csr_wdat), 64'((wb_dat_w >> (8*ln)) & 32'hFF));
        end
        chk("R6", "wb_ack", 64'(wb_ack), 64'(m_cnt == L + 2));
        if (m_cnt == L + 2) chk("R5", "wb_dat_r", 64'(wb_dat_r), 64'(m_hold));
      end
    end
  end

  task automatic access(input bit we, input logic [7:0] a, input logic [3:0] s,
                        input logic [31:0] d, output logic [31:0] r, output int lat);
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = we; wb_adr = a; wb_sel = s; wb_dat_w = d;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!wb_ack);
    r = wb_dat_r;
    wb_cyc = 0; wb_stb = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R6 watchdog: no completion");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int lat;
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk("R1", "reset re/we/ack", {61'd0, csr_re, csr_we, wb_ack}, 64'd0);
    rst_n = 1;
    @(negedge clk);

    wq.delete();
    access(1, 8'd3, 4'b1111, 32'h44332211, r, lat);
    chk("R6", "ack latency", 64'(lat), 64'(L + 2));
    chk("R2", "write order count", 64'(wq.size()), 64'd4);
    if (wq.size() == 4)
      chk("R2", "write order", {wq[0], wq[1], wq[2], wq[3]}, {10'd12, 10'd13, 10'd14, 10'd15});
    chk("R3", "lanes in slave", {mem[15], mem[14], mem[13], mem[12]}, 64'h44332211);

    access(0, 8'd3, 4'b1111, 32'h0, r, lat);
    chk("R5", "full read", 64'(r), 64'h44332211);
    access(0, 8'd3, 4'b0110, 32'h0, r, lat);
    chk("R5", "masked read", 64'(r), 64'h00332200);

    access(1, 8'd3, 4'b0110, 32'hAABBCCDD, r, lat);
    access(0, 8'd3, 4'b1111, 32'h0, r, lat);
    chk("R4", "masked write", 64'(r), 64'h44BBCC11);

    wq.delete();
    access(1, 8'd3, 4'b0000, 32'hFFFFFFFF, r, lat);
    chk("R4", "no-select writes", 64'(wq.size()), 64'd0);
    access(0, 8'd3, 4'b1111, 32'h0, r, lat);
    chk("R4", "no-select unchanged", 64'(r), 64'h44BBCC11);

    // abandon after lane 0 (R7)
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = 1; wb_adr = 8'd9; wb_sel = 4'hF; wb_dat_w = 32'h12345678;
    @(negedge clk);
    @(negedge clk);
    wb_cyc = 0; wb_stb = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R7", "no ack after abandon", 64'(wb_ack), 64'd0);
    end
    chk("R7", "lane0 written", 64'(mem[36]), 64'h78);
    chk("R7", "lane1 untouched", 64'(mem[37]), 64'h06);

    // back-to-back with request held through ack (R8)
    access(1, 8'd20, 4'b1111, 32'h01020304, r, lat);
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = 1; wb_adr = 8'd21; wb_sel = 4'hF; wb_dat_w = 32'hCAFEF00D;
    do @(negedge clk); while (!wb_ack);
    wb_we = 0; wb_adr = 8'd20; wb_sel = 4'b1001;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!wb_ack);
    chk("R8", "back-to-back spacing", 64'(lat), 64'(L + 3));
    chk("R8", "back-to-back read", 64'(wb_dat_r), 64'h01000004);
    wb_cyc = 0; wb_stb = 0;

    // equal width (R9)
    @(negedge clk);
    e_cyc = 1; e_stb = 1; e_we = 1; e_adr = 6'd5; e_sel = 1'b1; e_dat_w = 16'hBEEF;
    @(negedge clk);
    chk("R9", "single write strobe", {e_we_o, e_re, e_csr_adr, e_wdat}, {2'b10, 6'd5, 16'hBEEF});
    @(negedge clk);
    chk("R9", "no second strobe", {62'd0, e_we_o, e_ack}, 64'd0);
    @(negedge clk);
    chk("R9", "ack", 64'(e_ack), 64'd1);
    e_cyc = 0; e_stb = 0;
    @(negedge clk);
    e_cyc = 1; e_stb = 1; e_we = 0; e_adr = 6'd7;
    @(negedge clk);
    chk("R9", "single read strobe", {e_re, e_csr_adr}, {1'b1, 6'd7});
    @(negedge clk);
    @(negedge clk);
    chk("R9", "read ack data", {e_ack, e_dat_r}, {1'b1, 16'hA507});
    e_cyc = 0; e_stb = 0;

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule